// File: doc/BRIEF.md
# Streaming Intel HEX Record Loader

This block turns a stream of ASCII characters, delivered one per cycle while `in_valid` is high, into writes on a byte-wide program memory port. It follows the Intel HEX record layout and handles only data records and the end-of-file record. It checks every record against its checksum before any of that record's bytes reach memory.

A data record's payload is held in a small internal buffer while its checksum is unknown. When the checksum byte closes a valid data record, the buffered bytes are sent to the memory port in order, one per cycle. Four sticky flags report a bad character, a bad checksum, an over-long record and an unsupported record type. A sticky done flag is raised when a valid end-of-file record arrives, and the loader then ignores all input until reset. The memory itself sits outside the block.

Top module: `hexrec_loader`

## Requirements
- R1: The loader discards every character outside a record until it sees a colon (0x3A), which opens a record.
- R2: Within a record the decoded bytes come in this order: length, address high, address low, record type, the data bytes, then the checksum. Each byte is written as two hex characters, high nibble first.
- R3: The characters 0-9, A-F and a-f are hex digits of equal standing. Any other character inside a record, a colon included, abandons the record and sets `err_char`. That record writes nothing.
- R4: A record is valid only if the low 8 bits of the sum of all its decoded bytes, from the length byte to the checksum byte, are zero. Otherwise `err_sum` is set and the record writes nothing.
- R5: In a valid record of type 0x00, data byte n is written to address (start + n) mod 2^ADDR_W. The writes come in increasing n, on consecutive cycles. `mem_we` first rises two clock edges after the edge that accepts the last checksum character.
- R6: A valid type 0x00 record with length 0 writes nothing and sets no flag.
- R7: A length byte greater than MAX_LEN sets `err_len`, abandons the record and writes nothing.
- R8: A record type other than 0x00 or 0x01 sets `err_type`, abandons the record and writes nothing.
- R9: A valid type 0x01 record writes nothing and sets `ld_done`. The flag stays high until reset. While it is high, no input causes a write or changes any flag.
- R10: Every error flag stays set until reset. A record that starts after an error is still decoded and written normally.
- R11: After reset, `mem_we`, `ld_done` and all four error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_char` holds a character this cycle |
| in_char | input | 8 | ASCII character |
| mem_we | output | 1 | Program memory write strobe |
| mem_addr | output | ADDR_W | Program memory write address |
| mem_wdata | output | 8 | Program memory write data |
| ld_done | output | 1 | Sticky: valid end-of-file record seen |
| err_sum | output | 1 | Sticky: checksum mismatch |
| err_type | output | 1 | Sticky: unsupported record type |
| err_len | output | 1 | Sticky: record longer than MAX_LEN |
| err_char | output | 1 | Sticky: non-hex character inside a record |

## Verification
The bench builds the loader with ADDR_W = 16 and MAX_LEN = 8. With a buffer that small, every legal length from 0 to 8 can be swept, and the first illegal length, 9, is cheap to reach. Thirty-two records carry all 256 byte values in turn, alternating between upper-case and lower-case digits, so the digit decoder is covered exhaustively. A record that starts at 0xFFFE checks the address wrap. Each error and the end-of-file case runs from a fresh reset, so each sticky flag is seen on its own.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;
  typedef enum logic [2:0] {
    S_HUNT,   // waiting for a colon
    S_HEAD,   // length, address, type
    S_DATA,   // payload bytes
    S_SUM,    // checksum byte
    S_WRITE,  // draining buffer to memory
    S_DONE    // end of file reached
  } pstate_t;
endpackage

// File: rtl/hexrec_digit.sv
module hexrec_digit (
  input  logic [7:0] ch,
  output logic       ok,
  output logic [3:0] val
);
  always_comb begin
    ok  = 1'b1;
    val = 4'd0;
    if (ch >= 8'h30 && ch <= 8'h39)      val = 4'(ch - 8'h30);
    else if (ch >= 8'h41 && ch <= 8'h46) val = 4'(ch - 8'h37);
    else if (ch >= 8'h61 && ch <= 8'h66) val = 4'(ch - 8'h57);
    else                                 ok  = 1'b0;
  end
endmodule

// File: rtl/hexrec_buf.sv
module hexrec_buf #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] wa,
  input  logic [7:0]       wd,
  input  logic [IDX_W-1:0] ra,
  output logic [7:0]       rq
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rq <= mem[ra];
  end
endmodule

// File: rtl/hexrec_loader.sv
module hexrec_loader
  import hexrec_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int MAX_LEN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_char,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              ld_done,
  output logic              err_sum,
  output logic              err_type,
  output logic              err_len,
  output logic              err_char
);
  localparam int IDX_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam int LEN_W = $clog2(MAX_LEN + 1);

  pstate_t           st;
  logic [3:0]        hi_nib;
  logic              half;
  logic [1:0]        hidx;
  logic [7:0]        len_r, type_r, sum_r;
  logic [15:0]       addr_r;
  logic [LEN_W-1:0]  didx, widx, len_m1;
  logic              wr_v;
  logic [ADDR_W-1:0] wr_a;

  logic       dig_ok;
  logic [3:0] dig_val;
  logic [7:0] new_byte, sum_nx, buf_q;
  logic       byte_done, buf_we;

  hexrec_digit u_dig (.ch(in_char), .ok(dig_ok), .val(dig_val));

  assign new_byte  = {hi_nib, dig_val};
  assign sum_nx    = sum_r + new_byte;
  assign byte_done = in_valid && dig_ok && half;
  assign buf_we    = (st == S_DATA) && byte_done;
  assign len_m1    = LEN_W'(len_r) - LEN_W'(1);

  hexrec_buf #(.DEPTH(MAX_LEN), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .we(buf_we), .wa(didx[IDX_W-1:0]), .wd(new_byte),
    .ra(widx[IDX_W-1:0]), .rq(buf_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_HUNT; hi_nib <= '0; half <= 1'b0; hidx <= '0;
      len_r <= '0; type_r <= '0; sum_r <= '0; addr_r <= '0;
      didx <= '0; widx <= '0; wr_v <= 1'b0; wr_a <= '0;
      mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      ld_done <= 1'b0; err_sum <= 1'b0; err_type <= 1'b0;
      err_len <= 1'b0; err_char <= 1'b0;
    end else begin
      mem_we    <= wr_v;
      mem_addr  <= wr_a;
      mem_wdata <= buf_q;
      wr_v      <= 1'b0;
      case (st)
        S_HUNT: if (in_valid && in_char == 8'h3A) begin
          st <= S_HEAD; half <= 1'b0; hidx <= '0; sum_r <= '0;
        end
        S_HEAD, S_DATA, S_SUM: if (in_valid) begin
          if (!dig_ok) begin
            err_char <= 1'b1;
            st       <= S_HUNT;
          end else if (!half) begin
            hi_nib <= dig_val;
            half   <= 1'b1;
          end else begin
            half  <= 1'b0;
            sum_r <= sum_nx;
            if (st == S_HEAD) begin
              hidx <= hidx + 2'd1;
              case (hidx)
                2'd0: begin
                  len_r <= new_byte;
                  if (new_byte > 8'(MAX_LEN)) begin
                    err_len <= 1'b1;
                    st      <= S_HUNT;
                  end
                end
                2'd1: addr_r[15:8] <= new_byte;
                2'd2: addr_r[7:0]  <= new_byte;
                default: begin
                  type_r <= new_byte;
                  didx   <= '0;
                  if (new_byte > 8'd1) begin
                    err_type <= 1'b1;
                    st       <= S_HUNT;
                  end else begin
                    st <= (len_r == 8'd0) ? S_SUM : S_DATA;
                  end
                end
              endcase
            end else if (st == S_DATA) begin
              didx <= didx + LEN_W'(1);
              if (didx == len_m1) st <= S_SUM;
            end else begin
              widx <= '0;
              if (sum_nx != 8'd0) begin
                err_sum <= 1'b1;
                st      <= S_HUNT;
              end else if (type_r == 8'd1) begin
                ld_done <= 1'b1;
                st      <= S_DONE;
              end else begin
                st <= (len_r == 8'd0) ? S_HUNT : S_WRITE;
              end
            end
          end
        end
        S_WRITE: begin
          wr_v <= 1'b1;
          wr_a <= ADDR_W'(addr_r) + ADDR_W'(widx);
          widx <= widx + LEN_W'(1);
          if (widx == len_m1) st <= S_HUNT;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hexrec_loader_chk.sv
module hexrec_loader_chk #(
  parameter int ADDR_W  = 16,
  parameter int MAX_LEN = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              ld_done,
  input logic              err_sum,
  input logic              err_type,
  input logic              err_len,
  input logic              err_char
);
  localparam int RUN_W = $clog2(MAX_LEN + 2) + 1;
  logic [RUN_W-1:0] run;

  always_ff @(posedge clk) begin
    if (rst)                 run <= '0;
    else if (!mem_we)        run <= '0;
    else if (run != '1)      run <= run + RUN_W'(1);
  end

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    ld_done |=> ld_done);
  p_no_write_done_r9: assert property (@(posedge clk) disable iff (rst)
    ld_done |=> !mem_we);
  p_sum_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    err_sum |=> err_sum);
  p_type_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    err_type |=> err_type);
  p_len_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    err_len |=> err_len);
  p_char_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    err_char |=> err_char);
  p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));
  p_burst_bound_r7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (run < RUN_W'(MAX_LEN)));
endmodule

bind hexrec_loader hexrec_loader_chk #(.ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN)) u_chk (
  .clk(clk), .rst(rst), .mem_we(mem_we), .mem_addr(mem_addr),
  .ld_done(ld_done), .err_sum(err_sum), .err_type(err_type),
  .err_len(err_len), .err_char(err_char)
);

// File: tb/hexrec_loader_test.sv
module hexrec_loader_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_char = 8'h00;
  logic        mem_we, ld_done, err_sum, err_type, err_len, err_char;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;

  int tests = 0, fails = 0, nw = 0;
  bit finished = 1'b0;
  logic [7:0]  dat [16];
  logic [15:0] la [32];
  logic [7:0]  ld [32];

  always #4 clk = ~clk;

  hexrec_loader #(.ADDR_W(16), .MAX_LEN(8)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .ld_done(ld_done), .err_sum(err_sum), .err_type(err_type),
    .err_len(err_len), .err_char(err_char)
  );

  always @(negedge clk) if (!rst && mem_we) begin
    if (nw < 32) begin la[nw] = mem_addr; ld[nw] = mem_wdata; end
    nw = nw + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic [7:0] hx(input [3:0] v, input bit lc);
    if (v < 4'd10) return 8'h30 + 8'(v);
    return (lc ? 8'h61 : 8'h41) + 8'(v) - 8'd10;
  endfunction

  task automatic put_char(input [7:0] c);
    @(negedge clk); in_char = c; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic put_byte(input [7:0] b, input bit lc);
    put_char(hx(b[7:4], lc)); put_char(hx(b[3:0], lc));
  endtask

  task automatic put_rec(input [7:0] len, input [15:0] a, input [7:0] ty,
                         input [7:0] cadj, input bit lc);
    logic [7:0] s;
    s = len + a[15:8] + a[7:0] + ty;
    put_char(8'h3A);
    put_byte(len, lc); put_byte(a[15:8], lc); put_byte(a[7:0], lc); put_byte(ty, lc);
    for (int i = 0; i < int'(len) && i < 16; i++) begin
      s = s + dat[i]; put_byte(dat[i], lc);
    end
    put_byte(8'(8'd0 - s) + cadj, lc);
    repeat (30) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk); rst = 1'b0; nw = 0;
  endtask

  task automatic check_writes(input int len, input [15:0] a, input string req);
    check(nw == len, req, nw, len);
    for (int i = 0; i < len && i < nw && i < 32; i++) begin
      check(la[i] == 16'(a + 16'(i)), req, la[i], 16'(a + 16'(i)));
      check(ld[i] == dat[i], req, ld[i], dat[i]);
    end
  endtask

  task automatic check_flags(input bit d, input bit s, input bit t, input bit l,
                             input bit c, input string req);
    check({ld_done, err_sum, err_type, err_len, err_char} == {d, s, t, l, c}, req,
          {ld_done, err_sum, err_type, err_len, err_char}, {d, s, t, l, c});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check(mem_we == 1'b0, "R11", mem_we, 0);
    check_flags(0, 0, 0, 0, 0, "R11");

    // R1 R2 R5 R6: every legal length, garbage between records
    for (int n = 0; n <= 8; n++) begin
      for (int i = 0; i < 16; i++) dat[i] = 8'(n * 29 + i * 7 + 3);
      put_char("z"); put_char(8'h0D); put_char(8'h0A);
      nw = 0;
      put_rec(8'(n), 16'h1230 + 16'(n * 16), 8'h00, 8'h00, 1'b0);
      check_writes(n, 16'h1230 + 16'(n * 16), n == 0 ? "R6" : "R5");
    end
    check_flags(0, 0, 0, 0, 0, "R1");

    // R3: all byte values, upper and lower case digits
    for (int r = 0; r < 32; r++) begin
      for (int i = 0; i < 8; i++) dat[i] = 8'(r * 8 + i);
      nw = 0;
      put_rec(8'd8, 16'(r * 8), 8'h00, 8'h00, r[0]);
      check_writes(8, 16'(r * 8), "R3");
    end
    check_flags(0, 0, 0, 0, 0, "R3");

    // R5 address wrap
    for (int i = 0; i < 4; i++) dat[i] = 8'hA0 + 8'(i);
    nw = 0;
    put_rec(8'd4, 16'hFFFE, 8'h00, 8'h00, 1'b0);
    check_writes(4, 16'hFFFE, "R5");

    // R4 bad checksum, then R10 recovery
    do_reset();
    for (int i = 0; i < 3; i++) dat[i] = 8'h11 * 8'(i + 1);
    put_rec(8'd3, 16'h0040, 8'h00, 8'h01, 1'b0);
    check(nw == 0, "R4", nw, 0);
    check_flags(0, 1, 0, 0, 0, "R4");
    put_rec(8'd3, 16'h0050, 8'h00, 8'h00, 1'b1);
    check_writes(3, 16'h0050, "R10");
    check_flags(0, 1, 0, 0, 0, "R10");

    // R7 over-long record
    do_reset();
    for (int i = 0; i < 9; i++) dat[i] = 8'h20 + 8'(i);
    put_rec(8'd9, 16'h0100, 8'h00, 8'h00, 1'b0);
    check(nw == 0, "R7", nw, 0);
    check_flags(0, 0, 0, 1, 0, "R7");

    // R8 unsupported type
    do_reset();
    put_rec(8'd2, 16'h0000, 8'h02, 8'h00, 1'b0);
    check(nw == 0, "R8", nw, 0);
    check_flags(0, 0, 1, 0, 0, "R8");

    // R3 bad character in data field
    do_reset();
    put_char(8'h3A); put_byte(8'd3, 0); put_byte(8'h10, 0); put_byte(8'h00, 0);
    put_byte(8'h00, 0); put_char("G"); put_char("0");
    repeat (30) @(negedge clk);
    check(nw == 0, "R3", nw, 0);
    check_flags(0, 0, 0, 0, 1, "R3");

    // R3 colon inside a record, then R10 recovery
    do_reset();
    put_char(8'h3A); put_char("0"); put_char(8'h3A);
    check_flags(0, 0, 0, 0, 1, "R3");
    for (int i = 0; i < 2; i++) dat[i] = 8'h5A + 8'(i);
    put_rec(8'd2, 16'h0300, 8'h00, 8'h00, 1'b0);
    check_writes(2, 16'h0300, "R10");

    // R9 end of file, later input ignored
    do_reset();
    put_rec(8'd0, 16'h0000, 8'h01, 8'h00, 1'b0);
    check(nw == 0, "R9", nw, 0);
    check_flags(1, 0, 0, 0, 0, "R9");
    for (int i = 0; i < 3; i++) dat[i] = 8'h77;
    put_rec(8'd3, 16'h0400, 8'h00, 8'h00, 1'b0);
    put_char(8'h3A); put_char("#");
    put_rec(8'd2, 16'h0400, 8'h00, 8'h05, 1'b0);
    repeat (10) @(negedge clk);
    check(nw == 0, "R9", nw, 0);
    check_flags(1, 0, 0, 0, 0, "R9");

    // R4 end of file with bad checksum
    do_reset();
    put_rec(8'd0, 16'h0000, 8'h01, 8'h01, 1'b0);
    check_flags(0, 1, 0, 0, 0, "R4");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule